// File: doc/BRIEF.md
# Atomic Memory and Reservation Unit

This block is a small word-addressed shared memory with a synchronization front end. Several requesters share one request port. Each requester presents an operation code, an address and a write word on its own valid/ready channel. An arbiter accepts at most one request per cycle, using round-robin or fixed lowest-index priority as chosen by a parameter. The accepted operation runs to completion in the cycle it is accepted, so two read-modify-write sequences from different requesters can never interleave.

The unit supports plain load and store, atomic exchange, fetch-and-increment, and a load-linked / store-conditional pair. Each requester owns one reservation slot. A load-linked fills that slot with the address it read. Any write that lands on the reserved address cancels the reservation. A store-conditional only writes when the requester still holds a reservation on the same address. For lock words, 0 means free and 1 means held. An exchange of 1 that returns 0 means the caller now owns the lock.

Each accepted request produces exactly one response on a single valid/ready output stream. The response carries the requester index and a result word. Back-pressure rule: once a response is valid it stays valid and unchanged until `rsp_ready` is high at a clock edge. While a response is waiting and `rsp_ready` is low, no request is accepted. A request that is accepted in the same cycle a pending response drains produces the next response one cycle later, so the stream can carry one result per clock.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset no response is valid, every memory word reads 0, and no requester holds a reservation (a store-conditional right after reset returns 0).
- R2: A load (opcode 0) returns the word at the address. A store (opcode 1) writes the write word and returns 0.
- R3: An exchange (opcode 2) returns the old word and writes the write word in the same operation. On a lock word, exchanging 1 returns 0 to the first caller and 1 to every later caller until the word is cleared.
- R4: A fetch-and-increment (opcode 3) returns the old word and writes old + 1, wrapping from all-ones to 0.
- R5: A load-linked (opcode 4) returns the word and leaves memory unchanged.
- R6: A store-conditional (opcode 5) from a requester whose reservation is valid and on the same address writes the word and returns 1. A store-conditional result is always 0 or 1.
- R7: A store, exchange, fetch-and-increment or successful store-conditional to an address cancels every reservation on that address. A later store-conditional against a cancelled reservation returns 0 and leaves memory unchanged.
- R8: A store-conditional from a requester with no reservation, or with a reservation on a different address, returns 0 and does not write.
- R9: A store-conditional always clears the issuing requester's own reservation, whether it succeeds or fails.
- R10: Writes to other addresses do not disturb a reservation.
- R11: At most one request is accepted per cycle. Ready is only given to a requester that is valid. In round-robin mode, the search for the next grant starts at the requester after the one granted last. Each accepted request produces a response one cycle later that carries its requester index.
- R12: While a response is valid and `rsp_ready` is low, the response holds its value and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Per-requester request valid |
| req_ready | output | NUM_REQ | Per-requester request accepted |
| req_op | input | NUM_REQ*3 | Per-requester opcode, requester i at bits [3i+:3] |
| req_addr | input | NUM_REQ*ADDR_W | Per-requester word address |
| req_wdata | input | NUM_REQ*DATA_W | Per-requester write word |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_id | output | ID_W | Index of the requester the response belongs to |
| rsp_data | output | DATA_W | Result word |

## Verification
Two things can fall in the same cycle: a write that cancels reservations, and a reservation check or update from another requester. The bench provokes this by having two requesters link the same word and then letting one of them succeed. It also sends an exchange or increment between a link and its conditional store. Each case is judged by the 0/1 result and by reading the word back. A second collision is a response held under back-pressure while another requester waits. There the bench checks that the held word stays unchanged, that the waiting requester sees no ready, and that all four simultaneous requests drain in rotating order.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_LOAD  = 3'd0;
  localparam logic [OP_W-1:0] OP_STORE = 3'd1;
  localparam logic [OP_W-1:0] OP_SWAP  = 3'd2;
  localparam logic [OP_W-1:0] OP_FINC  = 3'd3;
  localparam logic [OP_W-1:0] OP_LL    = 3'd4;
  localparam logic [OP_W-1:0] OP_SC    = 3'd5;
endpackage

// File: rtl/amu_arbiter.sv
module amu_arbiter #(
  parameter int NUM_REQ     = 4,
  parameter bit ROUND_ROBIN = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REQ-1:0]         req,
  input  logic                       advance,
  output logic [NUM_REQ-1:0]         grant,
  output logic [$clog2(NUM_REQ)-1:0] gid
);
  localparam int ID_W = $clog2(NUM_REQ);

  generate
    if (ROUND_ROBIN) begin : g_rr
      logic [ID_W-1:0] last_q;

      always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
          int idx;
          idx = (int'(last_q) + 1 + k) % NUM_REQ;
          if (!found && req[idx]) begin
            grant[idx] = 1'b1;
            found      = 1'b1;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) last_q <= ID_W'(NUM_REQ - 1);
        else if (advance) last_q <= gid;
      end
    end else begin : g_fixed
      always_comb begin
        grant = '0;
        for (int k = NUM_REQ - 1; k >= 0; k--) begin
          if (req[k]) grant = NUM_REQ'(1) << k;
        end
      end
    end
  endgenerate

  always_comb begin
    gid = '0;
    for (int k = 0; k < NUM_REQ; k++) begin
      if (grant[k]) gid = ID_W'(k);
    end
  end
endmodule

// File: rtl/amu_resv_table.sv
module amu_resv_table #(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fire,
  input  logic [$clog2(NUM_REQ)-1:0] id,
  input  logic [amu_pkg::OP_W-1:0]   op,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       mem_we,
  output logic                       sc_pass
);
  import amu_pkg::*;

  logic [NUM_REQ-1:0] held_q;
  logic [ADDR_W-1:0]  where_q [NUM_REQ];

  assign sc_pass = held_q[id] && (where_q[id] == addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      for (int i = 0; i < NUM_REQ; i++) where_q[i] <= '0;
    end else if (fire) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        if (mem_we && held_q[i] && (where_q[i] == addr)) held_q[i] <= 1'b0;
      end
      if (op == OP_SC) held_q[id] <= 1'b0;
      if (op == OP_LL) begin
        held_q[id]  <= 1'b1;
        where_q[id] <= addr;
      end
    end
  end
endmodule

// File: rtl/amu_exec.sv
module amu_exec #(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fire,
  input  logic [$clog2(NUM_REQ)-1:0] id,
  input  logic [amu_pkg::OP_W-1:0]   op,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       sc_pass,
  output logic                       mem_we,
  output logic                       can_accept,
  input  logic                       rsp_ready,
  output logic                       rsp_valid,
  output logic [$clog2(NUM_REQ)-1:0] rsp_id,
  output logic [DATA_W-1:0]          rsp_data
);
  import amu_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] old_word, new_word, result;
  logic              wants_write;

  assign old_word = mem_q[addr];

  always_comb begin
    wants_write = 1'b0;
    new_word    = wdata;
    result      = old_word;
    case (op)
      OP_STORE: begin wants_write = 1'b1; result = '0; end
      OP_SWAP:  wants_write = 1'b1;
      OP_FINC:  begin wants_write = 1'b1; new_word = old_word + DATA_W'(1); end
      OP_SC:    begin wants_write = sc_pass; result = DATA_W'(sc_pass); end
      default:  ;
    endcase
  end

  assign mem_we     = fire && wants_write;
  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (mem_we) begin
      mem_q[addr] <= new_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_id    <= id;
      rsp_data  <= result;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
  parameter int NUM_REQ     = 4,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter bit ROUND_ROBIN = 1'b1,
  localparam int ID_W       = $clog2(NUM_REQ),
  localparam int OPW        = amu_pkg::OP_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REQ-1:0]         req_valid,
  output logic [NUM_REQ-1:0]         req_ready,
  input  logic [NUM_REQ*OPW-1:0]     req_op,
  input  logic [NUM_REQ*ADDR_W-1:0]  req_addr,
  input  logic [NUM_REQ*DATA_W-1:0]  req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [ID_W-1:0]            rsp_id,
  output logic [DATA_W-1:0]          rsp_data
);
  logic [NUM_REQ-1:0] grant;
  logic [ID_W-1:0]    gid;
  logic               can_accept, fire, sc_pass, mem_we;
  logic [OPW-1:0]     sel_op;
  logic [ADDR_W-1:0]  sel_addr;
  logic [DATA_W-1:0]  sel_wdata;

  assign fire      = (|grant) && can_accept;
  assign req_ready = grant & {NUM_REQ{can_accept}};
  assign sel_op    = req_op[gid*OPW +: OPW];
  assign sel_addr  = req_addr[gid*ADDR_W +: ADDR_W];
  assign sel_wdata = req_wdata[gid*DATA_W +: DATA_W];

  amu_arbiter #(.NUM_REQ(NUM_REQ), .ROUND_ROBIN(ROUND_ROBIN)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .advance(fire),
    .grant(grant), .gid(gid)
  );

  amu_resv_table #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_resv (
    .clk(clk), .rst_n(rst_n), .fire(fire), .id(gid), .op(sel_op),
    .addr(sel_addr), .mem_we(mem_we), .sc_pass(sc_pass)
  );

  amu_exec #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .fire(fire), .id(gid), .op(sel_op),
    .addr(sel_addr), .wdata(sel_wdata), .sc_pass(sc_pass), .mem_we(mem_we),
    .can_accept(can_accept), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_id(rsp_id), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int NUM_REQ = 4,
  parameter int DATA_W  = 32,
  localparam int ID_W   = $clog2(NUM_REQ),
  localparam int OPW    = amu_pkg::OP_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_REQ-1:0]     req_valid,
  input logic [NUM_REQ-1:0]     req_ready,
  input logic [NUM_REQ*OPW-1:0] req_op,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [ID_W-1:0]        rsp_id,
  input logic [DATA_W-1:0]      rsp_data
);
  logic [ID_W-1:0] acc_id;
  logic [OPW-1:0]  acc_op;
  logic            any_acc;

  assign any_acc = |(req_valid & req_ready);

  always_comb begin
    acc_id = '0;
    acc_op = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req_valid[i] && req_ready[i]) begin
        acc_id = ID_W'(i);
        acc_op = req_op[i*OPW +: OPW];
      end
    end
  end

  a_r11_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_valid & req_ready));

  a_r11_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    any_acc |=> (rsp_valid && rsp_id == $past(acc_id)));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_id)));

  a_r12_no_accept_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (req_ready == '0));

  a_r6_sc_boolean: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && acc_op == amu_pkg::OP_SC) |=> (rsp_data[DATA_W-1:1] == '0));
endmodule

bind atomic_mem_unit amu_checker #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/atomic_mem_unit_bench.sv
`timescale 1ns/1ps
module atomic_mem_unit_bench;
  localparam int N = 4, AW = 4, DW = 32, IW = 2;
  localparam logic [2:0] LD = 0, ST = 1, SW = 2, FI = 3, LL = 4, SC = 5;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_valid = '0;
  logic [N-1:0] req_ready;
  logic [N*3-1:0] req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [IW-1:0] rsp_id;
  logic [DW-1:0] rsp_data;

  int checks = 0, errors = 0, last_gid = N - 1;
  logic [IW+DW-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  atomic_mem_unit u_atomic_mem_unit (.*);

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(int id, logic [2:0] op, int addr, logic [DW-1:0] wd,
                       logic [DW-1:0] exp, string tag, bit push);
    bit acc;
    @(posedge clk); #1;
    req_op[id*3 +: 3]      = op;
    req_addr[id*AW +: AW]  = AW'(addr);
    req_wdata[id*DW +: DW] = wd;
    req_valid[id]          = 1'b1;
    acc = 0;
    while (!acc) begin
      @(negedge clk); acc = req_ready[id];
      @(posedge clk); #1;
    end
    req_valid[id] = 1'b0;
    last_gid = id;
    if (push) begin
      exp_q.push_back({IW'(id), exp});
      tag_q.push_back(tag);
    end
  endtask

  task automatic op1(int id, logic [2:0] op, int addr, logic [DW-1:0] wd,
                     logic [DW-1:0] exp, string tag);
    issue(id, op, addr, wd, exp, tag, 1'b1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        logic [IW+DW-1:0] e;
        string t;
        if (exp_q.size() == 0) begin
          chk(1'b0, "unexpected response", rsp_data, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_id == e[IW+DW-1:DW], {t, " id"}, DW'(rsp_id), DW'(e[IW+DW-1:DW]));
          chk(rsp_data == e[DW-1:0], {t, " data"}, rsp_data, e[DW-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 no response after reset", DW'(rsp_valid), 0);
    op1(0, LD, 3, 0, 0, "R1 memory zero");
    op1(1, SC, 3, 9, 0, "R1 no reservation after reset");
    op1(0, LD, 3, 0, 0, "R1 failed sc left word");

    op1(0, ST, 1, 32'h1234, 0, "R2 store result");
    op1(2, LD, 1, 0, 32'h1234, "R2 load back");

    op1(1, SW, 2, 1, 0, "R3 lock acquired");
    op1(2, SW, 2, 1, 1, "R3 lock already held");
    op1(0, LD, 2, 0, 1, "R3 lock word");
    op1(1, ST, 2, 0, 0, "R3 release");

    op1(3, FI, 4, 0, 0, "R4 finc first");
    op1(3, FI, 4, 0, 1, "R4 finc second");
    op1(3, ST, 4, 32'hFFFF_FFFF, 0, "R4 preset");
    op1(3, FI, 4, 0, 32'hFFFF_FFFF, "R4 finc at max");
    op1(0, LD, 4, 0, 0, "R4 wrap to zero");

    op1(0, LL, 5, 0, 0, "R5 ll value");
    op1(1, LD, 5, 0, 0, "R5 ll no write");
    op1(0, SC, 5, 77, 1, "R6 sc success");
    op1(1, LD, 5, 0, 77, "R6 sc wrote");

    op1(0, LL, 6, 0, 0, "R10 ll a");
    op1(1, LL, 6, 0, 0, "R7 ll b");
    op1(2, ST, 7, 5, 0, "R10 store elsewhere");
    op1(0, SC, 6, 11, 1, "R10 reservation survives");
    op1(1, SC, 6, 22, 0, "R7 cancelled by other sc");
    op1(2, LD, 6, 0, 11, "R7 word unchanged");

    op1(2, LL, 8, 0, 0, "R7 ll c");
    op1(3, FI, 8, 0, 0, "R7 finc between");
    op1(2, SC, 8, 9, 0, "R7 cancelled by finc");
    op1(0, LD, 8, 0, 1, "R7 finc value kept");

    op1(0, LL, 12, 0, 0, "R7 ll d");
    op1(1, SW, 12, 3, 0, "R7 swap between");
    op1(0, SC, 12, 8, 0, "R7 cancelled by swap");

    op1(3, LL, 9, 0, 0, "R8 ll e");
    op1(3, SC, 10, 4, 0, "R8 sc other address");
    op1(0, LD, 10, 0, 0, "R8 no write");
    op1(3, SC, 9, 5, 0, "R9 failed sc cleared own");
    op1(1, LL, 11, 0, 0, "R9 ll f");
    op1(1, SC, 11, 3, 1, "R9 first sc");
    op1(1, SC, 11, 4, 0, "R9 second sc fails");
    op1(2, LD, 11, 0, 3, "R9 word kept");
    drain();

    // R11: all requesters at once, round-robin order from last grant + 1
    begin
      logic [DW-1:0] vals [N];
      vals[0] = 32'h1234; vals[1] = 0; vals[2] = 0; vals[3] = 0;
      for (int k = 0; k < N; k++) begin
        int r;
        r = (last_gid + 1 + k) % N;
        exp_q.push_back({IW'(r), vals[r]});
        tag_q.push_back("R11 round robin order");
      end
      fork
        issue(0, LD, 1, 0, 0, "", 1'b0);
        issue(1, LD, 2, 0, 0, "", 1'b0);
        issue(2, LD, 3, 0, 0, "", 1'b0);
        issue(3, LD, 4, 0, 0, "", 1'b0);
      join
    end
    drain();

    // R12: back-pressure
    @(posedge clk); #2 rsp_ready = 1'b0;
    fork
      op1(0, LD, 1, 0, 32'h1234, "R12 held response");
      begin @(posedge clk); op1(1, LD, 5, 0, 77, "R12 waiting request"); end
      begin
        repeat (4) @(negedge clk);
        chk(rsp_valid == 1, "R12 valid held", DW'(rsp_valid), 1);
        chk(rsp_data == 32'h1234, "R12 data held", rsp_data, 32'h1234);
        chk(req_ready[1] == 0, "R12 no accept while full", DW'(req_ready[1]), 0);
        @(posedge clk); #2 rsp_ready = 1'b1;
      end
    join
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule